// File: doc/BRIEF.md
# Victim Line Buffer

This block is a small, fully associative store that sits beside a direct-mapped primary cache. It keeps the lines that the primary cache has recently thrown out. Each entry holds a whole line, its complete block address (tag and index together), a valid bit and a dirty bit. Whenever the primary cache evicts a line, it hands that line to the buffer through the insert port.

When the primary cache misses, it presents the requested block address on the lookup port. Along with it comes the line that the primary cache would displace to make room. On a hit, the buffer returns the stored line and its dirty state. The displaced primary line goes into the very entry that hit, so the two lines trade places and no memory access is needed. On a miss, nothing changes, and the primary cache goes on to memory.

Inserts fill free entries first. Once the buffer is full, an insert overwrites the least recently used entry, and a dirty line lost this way leaves through the writeback port.

Top module: `victim_buffer`

## Requirements
- R1: After reset no entry is valid; `rsp_valid`, `rsp_hit` and `wb_valid` are low, and any lookup misses.
- R2: A lookup request sampled at a rising edge yields `rsp_valid` high for exactly the following cycle. `rsp_hit`, `rsp_data` and `rsp_dirty` are valid in that same cycle. No response appears without a request.
- R3: On a lookup hit, the stored line and its dirty bit are returned. The displaced line (address, data, dirty) is written into the entry that hit, and that entry becomes most recently used. No other entry is lost and no writeback occurs, so the old address then misses and the displaced address then hits.
- R4: A lookup hit with `disp_valid` low frees the entry that hit. The next insert reuses that entry in preference to evicting a valid line.
- R5: A lookup miss returns `rsp_hit` low and leaves every entry and the recency order unchanged.
- R6: An insert goes to the lowest-numbered free entry when one exists, with no writeback.
- R7: When all entries are valid, an insert whose address matches no entry overwrites the least recently used entry. Recency is set by the most recent insert into an entry or hit on it, so the oldest surviving entry becomes the next to be replaced.
- R8: An insert that overwrites a valid dirty entry raises `wb_valid` for one cycle in the following cycle, carrying the old address and data. Overwriting a clean entry raises no writeback.
- R9: An insert whose address matches a valid entry updates that entry in place and makes it most recently used. Its dirty bit becomes the OR of the old and new dirty bits, and no writeback occurs.
- R10: When `req_valid` and `ins_valid` are high in the same cycle, the lookup is served and the insert is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insert an evicted primary line |
| ins_addr | input | ADDR_W | Block address of the inserted line |
| ins_data | input | DATA_W | Inserted line data |
| ins_dirty | input | 1 | Inserted line is modified |
| req_valid | input | 1 | Lookup request after a primary miss |
| req_addr | input | ADDR_W | Block address searched |
| disp_valid | input | 1 | Primary holds a line that the swap displaces |
| disp_addr | input | ADDR_W | Block address of the displaced line |
| disp_data | input | DATA_W | Displaced line data |
| disp_dirty | input | 1 | Displaced line is modified |
| rsp_valid | output | 1 | Lookup response strobe |
| rsp_hit | output | 1 | Lookup found the block |
| rsp_data | output | DATA_W | Line returned on a hit (zero on a miss) |
| rsp_dirty | output | 1 | Dirty state of the returned line |
| wb_valid | output | 1 | Dirty line forced out by an insert |
| wb_addr | output | ADDR_W | Block address of the written-back line |
| wb_data | output | DATA_W | Written-back line data |

## Verification
The bench first fills the buffer and then performs a swap. It checks that the swapped-out address misses while the displaced line hits. A design that fell back to LRU eviction on a hit would either drop a survivor or keep the stale line. It then forces an eviction of a dirty entry and an eviction of a clean entry, and frees an entry with an empty swap. A wrong design would show up as a spurious or missing writeback, or as a live line evicted while a free slot exists. The bench also sends an insert whose address is already present, with a clean copy, to catch a design that clears the dirty bit or duplicates the address. Finally it issues a simultaneous insert and lookup, to catch a design that lets the insert through.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [1:0] {
    VC_IDLE   = 2'd0,
    VC_LOOKUP = 2'd1,
    VC_INSERT = 2'd2
  } vc_op_e;
endpackage

// File: rtl/vc_match.sv
module vc_match #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 27,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic [ADDR_W-1:0]              key,
  input  logic [ENTRIES-1:0]             vld,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] tags,
  output logic                           hit,
  output logic [IW-1:0]                  hit_idx
);
  logic [ENTRIES-1:0] hit_vec;

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit_vec[g] = vld[g] && (tags[g] == key);
    end
  endgenerate

  assign hit = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) hit_idx = hit_idx | IW'(i);
    end
  end
endmodule

// File: rtl/vc_lru.sv
module vc_lru #(
  parameter int ENTRIES = 4,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               touch_en,
  input  logic [IW-1:0]      touch_idx,
  output logic [ENTRIES-1:0] lru_oh
);
  logic [ENTRIES-1:0][IW-1:0] age_q, age_d;
  logic [IW-1:0]              ref_age;

  assign ref_age = age_q[touch_idx];

  always_comb begin
    age_d = age_q;
    if (touch_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IW'(i) == touch_idx)    age_d[i] = '0;
        else if (age_q[i] < ref_age) age_d[i] = age_q[i] + 1'b1;
      end
    end
  end

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_age
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        age_q[g] <= IW'(g);
        else if (touch_en) age_q[g] <= age_d[g];
      end
      assign lru_oh[g] = (age_q[g] == IW'(ENTRIES - 1));
    end
  endgenerate
endmodule

// File: rtl/vc_pick.sv
module vc_pick #(
  parameter int ENTRIES = 4,
  localparam int IW     = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] vld,
  input  logic [ENTRIES-1:0] lru_oh,
  output logic [IW-1:0]      slot
);
  logic [IW-1:0] free_idx;
  logic [IW-1:0] lru_idx;
  logic          any_free;

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        free_idx = IW'(i);
        any_free = 1'b1;
      end
    end
  end

  always_comb begin
    lru_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lru_oh[i]) lru_idx = lru_idx | IW'(i);
    end
  end

  assign slot = any_free ? free_idx : lru_idx;
endmodule

// File: rtl/victim_buffer.sv
module victim_buffer #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 27,
  parameter int DATA_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [DATA_W-1:0] ins_data,
  input  logic              ins_dirty,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              disp_valid,
  input  logic [ADDR_W-1:0] disp_addr,
  input  logic [DATA_W-1:0] disp_data,
  input  logic              disp_dirty,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_dirty,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data
);
  import vc_pkg::*;

  localparam int IW = $clog2(ENTRIES);

  logic [ENTRIES-1:0]             vld_q, vld_d;
  logic [ENTRIES-1:0]             dty_q, dty_d;
  logic [ENTRIES-1:0][ADDR_W-1:0] tag_q, tag_d;
  logic [ENTRIES-1:0][DATA_W-1:0] dat_q, dat_d;
  logic [ENTRIES-1:0]             ent_we;

  logic              rsp_valid_d, rsp_hit_d, rsp_dirty_d;
  logic [DATA_W-1:0] rsp_data_d;
  logic              wb_valid_d;
  logic [ADDR_W-1:0] wb_addr_d;
  logic [DATA_W-1:0] wb_data_d;

  vc_op_e        op;
  logic          lk_hit, in_hit;
  logic [IW-1:0] lk_idx, in_idx, vic_idx, ins_slot;
  logic          touch_en;
  logic [IW-1:0] touch_idx;
  logic [ENTRIES-1:0] lru_oh;

  always_comb begin
    if (req_valid)      op = VC_LOOKUP;
    else if (ins_valid) op = VC_INSERT;
    else                op = VC_IDLE;
  end

  vc_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_lk_match (
    .key(req_addr), .vld(vld_q), .tags(tag_q), .hit(lk_hit), .hit_idx(lk_idx)
  );

  vc_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_in_match (
    .key(ins_addr), .vld(vld_q), .tags(tag_q), .hit(in_hit), .hit_idx(in_idx)
  );

  vc_pick #(.ENTRIES(ENTRIES)) u_pick (
    .vld(vld_q), .lru_oh(lru_oh), .slot(vic_idx)
  );

  vc_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_idx(touch_idx),
    .lru_oh(lru_oh)
  );

  assign ins_slot = in_hit ? in_idx : vic_idx;

  // Next-state decision for entries, recency and outputs.
  always_comb begin
    vld_d       = vld_q;
    dty_d       = dty_q;
    tag_d       = tag_q;
    dat_d       = dat_q;
    ent_we      = '0;
    touch_en    = 1'b0;
    touch_idx   = '0;
    rsp_valid_d = 1'b0;
    rsp_hit_d   = 1'b0;
    rsp_data_d  = '0;
    rsp_dirty_d = 1'b0;
    wb_valid_d  = 1'b0;
    wb_addr_d   = '0;
    wb_data_d   = '0;
    unique case (op)
      VC_LOOKUP: begin
        rsp_valid_d = 1'b1;
        if (lk_hit) begin
          rsp_hit_d        = 1'b1;
          rsp_data_d       = dat_q[lk_idx];
          rsp_dirty_d      = dty_q[lk_idx];
          ent_we[lk_idx]   = 1'b1;
          vld_d[lk_idx]    = disp_valid;
          tag_d[lk_idx]    = disp_addr;
          dat_d[lk_idx]    = disp_data;
          dty_d[lk_idx]    = disp_valid & disp_dirty;
          touch_en         = 1'b1;
          touch_idx        = lk_idx;
        end
      end
      VC_INSERT: begin
        wb_valid_d       = !in_hit && vld_q[ins_slot] && dty_q[ins_slot];
        wb_addr_d        = tag_q[ins_slot];
        wb_data_d        = dat_q[ins_slot];
        ent_we[ins_slot] = 1'b1;
        vld_d[ins_slot]  = 1'b1;
        tag_d[ins_slot]  = ins_addr;
        dat_d[ins_slot]  = ins_data;
        dty_d[ins_slot]  = ins_dirty | (in_hit & dty_q[ins_slot]);
        touch_en         = 1'b1;
        touch_idx        = ins_slot;
      end
      default: ;
    endcase
  end

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q[g] <= 1'b0;
          dty_q[g] <= 1'b0;
        end else if (ent_we[g]) begin
          vld_q[g] <= vld_d[g];
          dty_q[g] <= dty_d[g];
        end
      end
      always_ff @(posedge clk) begin
        if (ent_we[g]) begin
          tag_q[g] <= tag_d[g];
          dat_q[g] <= dat_d[g];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_data  <= '0;
      rsp_dirty <= 1'b0;
      wb_valid  <= 1'b0;
      wb_addr   <= '0;
      wb_data   <= '0;
    end else begin
      rsp_valid <= rsp_valid_d;
      rsp_hit   <= rsp_hit_d;
      rsp_data  <= rsp_data_d;
      rsp_dirty <= rsp_dirty_d;
      wb_valid  <= wb_valid_d;
      wb_addr   <= wb_addr_d;
      wb_data   <= wb_data_d;
    end
  end
endmodule

// File: rtl/victim_buffer_chk.sv
module victim_buffer_chk #(
  parameter int ENTRIES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               ins_valid,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               wb_valid,
  input logic [ENTRIES-1:0] vld_q,
  input logic [ENTRIES-1:0] lru_oh
);
  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r2_no_rsp_without_req: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r1_hit_only_in_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);
  a_r5_miss_keeps_entries: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> $stable(vld_q));
  a_r3_swap_no_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !wb_valid);
  a_r4_swap_never_adds: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> ($countones(vld_q) <= $countones($past(vld_q))));
  a_r6_wb_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(&vld_q));
  a_r8_wb_from_insert: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(ins_valid && !req_valid));
  a_r7_single_lru: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lru_oh) == 1);
endmodule

bind victim_buffer victim_buffer_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ins_valid(ins_valid),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .wb_valid(wb_valid),
  .vld_q(vld_q), .lru_oh(lru_oh)
);

// File: tb/victim_buffer_tb_top.sv
`timescale 1ns/1ps
module victim_buffer_tb_top;
  localparam int AW = 27;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ins_valid, ins_dirty, req_valid, disp_valid, disp_dirty;
  logic [AW-1:0] ins_addr, req_addr, disp_addr;
  logic [DW-1:0] ins_data, disp_data;
  logic          rsp_valid, rsp_hit, rsp_dirty, wb_valid;
  logic [DW-1:0] rsp_data, wb_data;
  logic [AW-1:0] wb_addr;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int            due;
    logic          hit;
    logic [DW-1:0] data;
    logic          dirty;
    string         tag;
  } rsp_exp_t;

  typedef struct {
    int            due;
    logic          vld;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    string         tag;
  } wb_exp_t;

  rsp_exp_t rsp_q[$];
  wb_exp_t  wb_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  victim_buffer #(.ENTRIES(4), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_addr(ins_addr), .ins_data(ins_data), .ins_dirty(ins_dirty),
    .req_valid(req_valid), .req_addr(req_addr),
    .disp_valid(disp_valid), .disp_addr(disp_addr), .disp_data(disp_data), .disp_dirty(disp_dirty),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data), .rsp_dirty(rsp_dirty),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic idle_inputs();
    ins_valid = 0; ins_addr = '0; ins_data = '0; ins_dirty = 0;
    req_valid = 0; req_addr = '0;
    disp_valid = 0; disp_addr = '0; disp_data = '0; disp_dirty = 0;
  endtask

  // Driver: called at a falling edge, holds the request for one clock.
  task automatic do_insert(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic dt,
                           input logic exp_wb, input logic [AW-1:0] wa,
                           input logic [DW-1:0] wd, input string tag);
    wb_exp_t e;
    ins_valid = 1; ins_addr = a; ins_data = d; ins_dirty = dt;
    e.due = cyc + 1; e.vld = exp_wb; e.addr = wa; e.data = wd; e.tag = tag;
    wb_q.push_back(e);
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_lookup(input logic [AW-1:0] a, input logic dv, input logic [AW-1:0] da,
                           input logic [DW-1:0] dd, input logic ddt,
                           input logic eh, input logic [DW-1:0] ed, input logic edt,
                           input string tag);
    rsp_exp_t e;
    req_valid = 1; req_addr = a;
    disp_valid = dv; disp_addr = da; disp_data = dd; disp_dirty = ddt;
    e.due = cyc + 1; e.hit = eh; e.data = ed; e.dirty = edt; e.tag = tag;
    rsp_q.push_back(e);
    @(negedge clk);
    idle_inputs();
  endtask

  // Monitor: compares outputs one falling edge after each request.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (rsp_q.size() > 0 && rsp_q[0].due == cyc) begin
          rsp_exp_t e;
          e = rsp_q.pop_front();
          check(rsp_valid === 1'b1 && rsp_hit === e.hit &&
                (!e.hit || (rsp_data === e.data && rsp_dirty === e.dirty)), e.tag,
                $sformatf("rsp v=%0b hit=%0b data=%h dirty=%0b exp hit=%0b data=%h dirty=%0b",
                          rsp_valid, rsp_hit, rsp_data, rsp_dirty, e.hit, e.data, e.dirty));
        end else if (rsp_valid !== 1'b0) begin
          check(0, "R2", $sformatf("rsp_valid=%0b exp 0 (no request)", rsp_valid));
        end
        if (wb_q.size() > 0 && wb_q[0].due == cyc) begin
          wb_exp_t w;
          w = wb_q.pop_front();
          check(wb_valid === w.vld && (!w.vld || (wb_addr === w.addr && wb_data === w.data)),
                w.tag, $sformatf("wb v=%0b addr=%h data=%h exp v=%0b addr=%h data=%h",
                                 wb_valid, wb_addr, wb_data, w.vld, w.addr, w.data));
        end else if (wb_valid !== 1'b0) begin
          check(0, "R8", $sformatf("wb_valid=%0b exp 0 (no insert)", wb_valid));
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: quiet outputs after reset
    check(rsp_valid === 0 && rsp_hit === 0 && wb_valid === 0, "R1",
          $sformatf("rsp_valid=%0b rsp_hit=%0b wb_valid=%0b exp 0 0 0", rsp_valid, rsp_hit, wb_valid));
    do_lookup(27'h10, 0, '0, '0, 0, 0, '0, 0, "R1 lookup after reset");

    // R6: fill free entries, no writeback
    do_insert(27'h1, 64'h1111, 0, 0, '0, '0, "R6 fill 1");
    do_insert(27'h2, 64'h2222, 1, 0, '0, '0, "R6 fill 2");
    do_insert(27'h3, 64'h3333, 0, 0, '0, '0, "R6 fill 3");
    do_insert(27'h4, 64'h4444, 0, 0, '0, '0, "R6 fill 4");

    // R3: swap on hit
    do_lookup(27'h3, 1, 27'h33, 64'hD33, 1, 1, 64'h3333, 0, "R3 swap hit");
    do_lookup(27'h3, 0, '0, '0, 0, 0, '0, 0, "R3 old line gone");

    // R7/R8: LRU replacement, clean then dirty victim
    do_insert(27'h5, 64'h5555, 0, 0, '0, '0, "R7 evict clean LRU");
    do_insert(27'h6, 64'h6666, 0, 1, 27'h2, 64'h2222, "R8 evict dirty LRU");
    do_lookup(27'h1, 0, '0, '0, 0, 0, '0, 0, "R7 evicted line 1");
    do_lookup(27'h2, 0, '0, '0, 0, 0, '0, 0, "R5 miss no change");

    // R3/R4: displaced dirty line returned, then entry freed
    do_lookup(27'h33, 0, '0, '0, 0, 1, 64'hD33, 1, "R3 displaced line hit");
    do_insert(27'h7, 64'h7777, 0, 0, '0, '0, "R4 freed entry reused");
    do_lookup(27'h4, 1, 27'h44, 64'hD44, 1, 1, 64'h4444, 0, "R4 survivor kept");

    do_insert(27'h8, 64'h8888, 0, 0, '0, '0, "R7 evict clean");
    do_lookup(27'h5, 0, '0, '0, 0, 0, '0, 0, "R7 oldest gone");

    // R9: insert to present address
    do_insert(27'h44, 64'hE44, 0, 0, '0, '0, "R9 in-place insert");
    do_lookup(27'h44, 0, '0, '0, 0, 1, 64'hE44, 1, "R9 dirty kept");

    // R10: simultaneous lookup and insert
    ins_valid = 1; ins_addr = 27'h9; ins_data = 64'h9999; ins_dirty = 1;
    do_lookup(27'h99, 0, '0, '0, 0, 0, '0, 0, "R10 lookup served");
    do_lookup(27'h9, 0, '0, '0, 0, 0, '0, 0, "R10 insert dropped");

    // R7: recency ordering after a freed slot is refilled
    do_insert(27'hA, 64'hAAAA, 0, 0, '0, '0, "R6 refill free");
    do_insert(27'hB, 64'hBBBB, 0, 0, '0, '0, "R7 evict LRU");
    do_lookup(27'h6, 0, '0, '0, 0, 0, '0, 0, "R7 LRU victim gone");
    do_lookup(27'h7, 0, '0, '0, 0, 1, 64'h7777, 0, "R7 younger kept");

    repeat (3) @(negedge clk);
    check(rsp_q.size() == 0 && wb_q.size() == 0, "R2",
          $sformatf("pending rsp=%0d wb=%0d exp 0 0", rsp_q.size(), wb_q.size()));
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule